// File: doc/BRIEF.md
# I2C Master Register Front End

This block sits between a byte-wide host register port and a byte-level I2C master engine. The host sees eighteen byte registers. The block turns some of those register accesses into sequences of bus commands: start (with a 7-bit target address and a direction flag), send byte, receive byte and stop. Each command reports completion together with an acknowledge or refusal result. Bit-level SCL/SDA timing, clock division, slave operation and interrupt generation belong to other blocks.

Writing the data register sends a byte, and it first opens a write transfer if none is active. Writing the control register with both its go and read bits set opens a read transfer. Each later read of the data register receives one byte. A two-bit pending count in the control register decides whether the block stops and restarts the read to the same target after each byte, or whether the buffer-full flag is dropped. Status bits record pending, error and buffer-full conditions. One bit of the extended control register restores every register to its reset value.

A host access is held (`host_ready` low) until the whole bus sequence it triggered has finished. A data-register read therefore returns the received byte in the same access.

Top module: `iic_master_regfile`

## Requirements
- R1: After reset every register reads 0x00, except extended status (offset 9), which reads 0x8F, and direct control (offset 16), which reads 0x0F. Offset 0 reads 0xFF while the buffer-full status bit 5 is clear.
- R2: Writes are stored with these masks: mode control (offset 7) keeps value & 0xDF, transfer count (offset 14) keeps value & 0x77 and direct control (offset 16) keeps value & 0x07. Other plain registers, such as offsets 2, 5 and 12, store the value unchanged. Offsets 1, 3 and any offset of 18 or more read 0x00 and ignore writes.
- R3: A status write (offset 8) clears only the status bits selected by value & 0x0A. Error bit 2 and pending bit 0 are unaffected. An extended status write (offset 9) clears the bits selected by value & 0x8F.
- R4: Writing offset 0 while no transfer is active issues START (op 0) with the address taken from bits 7:1 of offset 4 and the read flag at 0. If the start is acknowledged, status bit 0 is set, status bit 2 is cleared, extended status becomes 0x00, and SEND (op 1) of the written byte follows.
- R5: A refused START issued by a data write clears status bit 0, sets status bit 2 and sets extended status bit 0, and no SEND follows. A refused SEND does the same and is followed by STOP (op 3).
- R6: Writing offset 0 while a transfer is active issues only SEND of the byte.
- R7: Writing offset 4 while a transfer is active issues STOP. Writing it while idle issues no command.
- R8: A control write (offset 6) with bits 1:0 = 11 first issues STOP and clears status bit 0 if a transfer is active, then issues START with the read flag at 1. Success sets status bit 5, clears bit 2 and zeroes extended status. Failure clears bit 0, sets bit 2 and sets extended status bit 0.
- R9: A control write with bits 1:0 = 01 issues no command and clears status bit 0. The control value is stored as written.
- R10: Reading offset 0 while status bit 5 is clear returns 0xFF and issues no command.
- R11: Reading offset 0 while status bit 5 is set issues RECEIVE (op 2) and returns the byte, or 0xFF if the receive is refused. The pending count is control bits 5:4. If the count is zero, status bit 5 clears and nothing follows. If it is nonzero, STOP is issued and then a read START to the same address. In both cases the field is then decremented modulo 4, so 0 becomes 3.
- R12: Writing offset 15 with bit 0 set returns every register to its R1 value and does not store the written value. With bit 0 clear, the value is stored as written.
- R13: A command's `cmd_valid` and its fields stay stable until `cmd_done`. `host_ready` is only given to an asserted `host_valid`, and it is withheld until the triggered command sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_write | input | 1 | 1 = register write, 0 = register read |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Access completes in this cycle |
| host_rdata | output | 8 | Read data, valid with host_ready |
| cmd_valid | output | 1 | Bus command request |
| cmd_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| cmd_read | output | 1 | Direction flag for start |
| cmd_addr | output | 7 | Target address for start |
| cmd_wdata | output | 8 | Byte for send |
| cmd_done | input | 1 | Command completed |
| cmd_nack | input | 1 | Command refused (with cmd_done) |
| cmd_rdata | input | 8 | Received byte (with cmd_done) |

## Verification
A wrong transfer-active flag appears on the command port as soon as the next data or address write is made. A missing or extra START, SEND or STOP shows up in the bench's command log for that same access. Errors in the pending count or the buffer-full flag show up in the data-register read immediately after: either the STOP/START pair appears when it should not, or it is missing, or the value read back from the control register is wrong. A slip in the status flags is visible on the next status read, because each step in the sequence is followed by a read-back of status and extended status.

// File: rtl/iic_master_regfile.sv
module iic_master_regfile #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              host_ready,
  output logic [7:0]        host_rdata,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic              cmd_read,
  output logic [6:0]        cmd_addr,
  output logic [7:0]        cmd_wdata,
  input  logic              cmd_done,
  input  logic              cmd_nack,
  input  logic [7:0]        cmd_rdata
);
  localparam int NREG = 18;
  localparam logic [ADDR_W-1:0] A_MD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_G1  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_G3  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LMA = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_EXT = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_XFR = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_XTC = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(16);

  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_WSTART, S_WSEND, S_STOP, S_RSTOP, S_RSTART, S_RECV, S_FIN
  } state_t;

  state_t     state;
  logic [7:0] rf [NREG];
  logic       busy;
  logic [7:0] hold;

  function automatic logic [7:0] rst_val(input int i);
    if (i == int'(A_EXT)) return 8'h8F;
    if (i == int'(A_DIR)) return 8'h0F;
    return 8'h00;
  endfunction

  wire       hit   = int'(host_addr) < NREG;
  wire       mdbs  = rf[A_STS][5];
  wire [1:0] pend  = rf[A_CTL][5:4];

  wire needs_bus = host_write
      ? (host_addr == A_MD) || (host_addr == A_LMA && busy) ||
        (host_addr == A_CTL && host_wdata[1:0] == 2'b11)
      : (host_addr == A_MD) && mdbs;

  assign host_ready = (state == S_FIN) || (state == S_IDLE && host_valid && !needs_bus);

  always_comb begin
    if (state == S_FIN)                              host_rdata = hold;
    else if (host_addr == A_MD)                      host_rdata = 8'hFF;
    else if (hit && host_addr != A_G1 && host_addr != A_G3) host_rdata = rf[host_addr];
    else                                             host_rdata = 8'h00;
  end

  assign cmd_valid = state inside {S_WSTART, S_WSEND, S_STOP, S_RSTOP, S_RSTART, S_RECV};
  assign cmd_read  = state == S_RSTART;
  assign cmd_addr  = rf[A_LMA][7:1];
  assign cmd_wdata = rf[A_MD];

  always_comb begin
    case (state)
      S_WSEND:         cmd_op = OP_SEND;
      S_RECV:          cmd_op = OP_RECV;
      S_STOP, S_RSTOP: cmd_op = OP_STOP;
      default:         cmd_op = OP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= rst_val(i);
      state <= S_IDLE;
      busy  <= 1'b0;
      hold  <= 8'h00;
    end else begin
      case (state)
        S_IDLE: if (host_valid) begin
          if (host_write && hit) begin
            case (host_addr)
              A_MD: begin
                rf[A_MD] <= host_wdata;
                state <= busy ? S_WSEND : S_WSTART;
              end
              A_G1, A_G3: ;
              A_LMA: begin
                rf[A_LMA] <= host_wdata;
                if (busy) state <= S_STOP;
              end
              A_CTL: begin
                rf[A_CTL] <= host_wdata;
                if (host_wdata[0]) begin
                  if (host_wdata[1]) begin
                    if (busy) begin
                      rf[A_STS][0] <= 1'b0;
                      state <= S_RSTOP;
                    end else state <= S_RSTART;
                  end else rf[A_STS][0] <= 1'b0;
                end
              end
              A_MOD: rf[A_MOD] <= host_wdata & 8'hDF;
              A_STS: rf[A_STS] <= rf[A_STS] & ~(host_wdata & 8'h0A);
              A_EXT: rf[A_EXT] <= rf[A_EXT] & ~(host_wdata & 8'h8F);
              A_XFR: rf[A_XFR] <= host_wdata & 8'h77;
              A_XTC: begin
                if (host_wdata[0]) for (int i = 0; i < NREG; i++) rf[i] <= rst_val(i);
                else rf[A_XTC] <= host_wdata;
              end
              A_DIR: rf[A_DIR] <= host_wdata & 8'h07;
              default: rf[host_addr] <= host_wdata;
            endcase
          end else if (!host_write && host_addr == A_MD && mdbs) begin
            state <= S_RECV;
          end
        end
        S_WSTART: if (cmd_done) begin
          if (cmd_nack) begin
            rf[A_STS][0] <= 1'b0; rf[A_STS][2] <= 1'b1; rf[A_EXT][0] <= 1'b1;
            state <= S_FIN;
          end else begin
            rf[A_STS][0] <= 1'b1; rf[A_STS][2] <= 1'b0; rf[A_EXT] <= 8'h00;
            busy  <= 1'b1;
            state <= S_WSEND;
          end
        end
        S_WSEND: if (cmd_done) begin
          if (cmd_nack) begin
            rf[A_STS][0] <= 1'b0; rf[A_STS][2] <= 1'b1; rf[A_EXT][0] <= 1'b1;
            state <= S_STOP;
          end else state <= S_FIN;
        end
        S_STOP: if (cmd_done) begin
          busy  <= 1'b0;
          state <= S_FIN;
        end
        S_RSTOP: if (cmd_done) begin
          busy  <= 1'b0;
          state <= S_RSTART;
        end
        S_RSTART: if (cmd_done) begin
          if (cmd_nack) begin
            rf[A_STS][0] <= 1'b0; rf[A_STS][2] <= 1'b1; rf[A_EXT][0] <= 1'b1;
            busy <= 1'b0;
          end else begin
            rf[A_STS][5] <= 1'b1; rf[A_STS][2] <= 1'b0; rf[A_EXT] <= 8'h00;
            busy <= 1'b1;
          end
          state <= S_FIN;
        end
        S_RECV: if (cmd_done) begin
          hold <= cmd_nack ? 8'hFF : cmd_rdata;
          rf[A_CTL][5:4] <= pend - 2'd1;
          if (pend == 2'd0) begin
            rf[A_STS][5] <= 1'b0;
            state <= S_FIN;
          end else state <= S_RSTOP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_read));

  assert_ready_needs_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> host_valid);

  assert_start_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_START && cmd_done && !cmd_nack |=> busy && rf[A_EXT] == 8'h00 && !rf[A_STS][2]);

  assert_start_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_START && cmd_done && cmd_nack |=> rf[A_STS][2] && rf[A_EXT][0] && !rf[A_STS][0]);

  assert_send_in_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_SEND |-> busy);

  assert_recv_needs_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_RECV |-> mdbs);

  assert_last_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_RECV && cmd_done && pend == 2'd0 |=> !mdbs && state == S_FIN);
endmodule

// File: tb/sim_iic_master_regfile.sv
module sim_iic_master_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0, host_write = 1'b0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_ready;
  logic [7:0] host_rdata;
  logic       cmd_valid, cmd_read;
  logic [1:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic       cmd_done = 1'b0, cmd_nack = 1'b0;
  logic [7:0] cmd_rdata = '0;

  iic_master_regfile #(.ADDR_W(5)) u0 (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic nack_start = 0, nack_send = 0, nack_recv = 0;
  logic [7:0] rx_byte = 8'h00;
  int ncmd = 0;
  logic [1:0] lg_op [64];
  logic [6:0] lg_addr [64];
  logic       lg_rd [64];
  logic [7:0] lg_wd [64];

  always @(negedge clk) begin
    if (cmd_done) cmd_done <= 1'b0;
    else if (cmd_valid) begin
      cmd_done  <= 1'b1;
      cmd_nack  <= (cmd_op == 2'd0 && nack_start) || (cmd_op == 2'd1 && nack_send) ||
                   (cmd_op == 2'd2 && nack_recv);
      cmd_rdata <= rx_byte;
      if (ncmd < 64) begin
        lg_op[ncmd] <= cmd_op; lg_addr[ncmd] <= cmd_addr;
        lg_rd[ncmd] <= cmd_read; lg_wd[ncmd] <= cmd_wdata;
      end
      ncmd <= ncmd + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [7:0] wd, output logic [7:0] rd);
    bit got = 0;
    int spin = 0;
    @(negedge clk);
    ncmd = 0;
    host_valid = 1; host_write = wr; host_addr = a; host_wdata = wd;
    rd = 8'h00;
    while (!got) begin
      #4;
      if (host_ready) begin got = 1; rd = host_rdata; end
      @(posedge clk);
      spin++;
      if (spin > 500) begin
        check("R13 host access hung", 0, 1);
        got = 1;
      end
    end
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] x;
    acc(1'b1, a, d, x);
  endtask

  task automatic rchk(string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] x;
    acc(1'b0, a, 8'h00, x);
    check(req, x, exp);
  endtask

  task automatic logchk(string req, int i, int op, int ad, int rdf, int wd);
    check({req, " cmd op"}, lg_op[i], op);
    if (op == 0) begin
      check({req, " start addr"}, lg_addr[i], ad);
      check({req, " start dir"}, lg_rd[i], rdf);
    end
    if (op == 1) check({req, " send byte"}, lg_wd[i], wd);
  endtask

  // {req, write, addr, wdata, expected read}. Rows tagged 2 cover R2, rows tagged 3 cover R3.
  localparam logic [25:0] VEC [22] = '{
    {4'd2, 1'b1, 5'd7,  8'hFF, 8'h00}, {4'd2, 1'b0, 5'd7,  8'h00, 8'hDF},
    {4'd2, 1'b1, 5'd14, 8'hFF, 8'h00}, {4'd2, 1'b0, 5'd14, 8'h00, 8'h77},
    {4'd2, 1'b1, 5'd16, 8'hFF, 8'h00}, {4'd2, 1'b0, 5'd16, 8'h00, 8'h07},
    {4'd2, 1'b1, 5'd2,  8'h5A, 8'h00}, {4'd2, 1'b0, 5'd2,  8'h00, 8'h5A},
    {4'd2, 1'b1, 5'd12, 8'hC3, 8'h00}, {4'd2, 1'b0, 5'd12, 8'h00, 8'hC3},
    {4'd2, 1'b1, 5'd5,  8'h81, 8'h00}, {4'd2, 1'b0, 5'd5,  8'h00, 8'h81},
    {4'd2, 1'b1, 5'd1,  8'hAA, 8'h00}, {4'd2, 1'b0, 5'd1,  8'h00, 8'h00},
    {4'd2, 1'b1, 5'd3,  8'h55, 8'h00}, {4'd2, 1'b0, 5'd3,  8'h00, 8'h00},
    {4'd2, 1'b1, 5'd20, 8'h77, 8'h00}, {4'd2, 1'b0, 5'd20, 8'h00, 8'h00},
    {4'd3, 1'b1, 5'd9,  8'h01, 8'h00}, {4'd3, 1'b0, 5'd9,  8'h00, 8'h8E},
    {4'd3, 1'b1, 5'd9,  8'h80, 8'h00}, {4'd3, 1'b0, 5'd9,  8'h00, 8'h0E}
  };

  initial begin
    #2000000;
    check("watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] x;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset values
    for (int i = 0; i < 18; i++) begin
      int e;
      e = (i == 0) ? 8'hFF : (i == 9) ? 8'h8F : (i == 16) ? 8'h0F : 0;
      rchk("R1 reset value", 5'(i), 8'(e));
    end

    for (int i = 0; i < 22; i++) begin
      logic [7:0] r;
      acc(VEC[i][21], VEC[i][20:16], VEC[i][15:8], r);
      if (!VEC[i][21]) check($sformatf("R%0d table row %0d", VEC[i][25:22], i), r, VEC[i][7:0]);
    end

    // R4: write transfer opened by data write
    wr(5'd4, 8'hA4);
    wr(5'd0, 8'h3C);
    check("R4 command count", ncmd, 2);
    logchk("R4", 0, 0, 7'h52, 0, 0);
    logchk("R4", 1, 1, 0, 0, 8'h3C);
    rchk("R4 status", 5'd8, 8'h01);
    rchk("R4 ext status", 5'd9, 8'h00);
    // R3: pending bit not in clear mask
    wr(5'd8, 8'hFF);
    rchk("R3 status mask", 5'd8, 8'h01);

    // R6: data write during active transfer
    wr(5'd0, 8'h11);
    check("R6 command count", ncmd, 1);
    logchk("R6", 0, 1, 0, 0, 8'h11);

    // R9
    wr(5'd6, 8'h01);
    check("R9 command count", ncmd, 0);
    rchk("R9 status", 5'd8, 8'h00);
    rchk("R9 control", 5'd6, 8'h01);

    // R7
    wr(5'd4, 8'hA4);
    check("R7 stop count", ncmd, 1);
    logchk("R7", 0, 3, 0, 0, 0);
    wr(5'd4, 8'hA4);
    check("R7 idle no command", ncmd, 0);

    // R5: refused start
    nack_start = 1;
    wr(5'd0, 8'h22);
    nack_start = 0;
    check("R5 no send after failed start", ncmd, 1);
    rchk("R5 status", 5'd8, 8'h04);
    rchk("R5 ext", 5'd9, 8'h01);
    // R5: refused send
    nack_send = 1;
    wr(5'd0, 8'h33);
    nack_send = 0;
    check("R5 command count", ncmd, 3);
    logchk("R5", 1, 1, 0, 0, 8'h33);
    logchk("R5", 2, 3, 0, 0, 0);
    rchk("R5 status after send", 5'd8, 8'h04);
    rchk("R5 ext after send", 5'd9, 8'h01);
    // R3: error bit not in clear mask
    wr(5'd8, 8'hFF);
    rchk("R3 error kept", 5'd8, 8'h04);

    // R10
    acc(1'b0, 5'd0, 8'h00, x);
    check("R10 data", x, 8'hFF);
    check("R10 no command", ncmd, 0);

    // R8 read start, pending 2
    wr(5'd6, 8'h23);
    check("R8 command count", ncmd, 1);
    logchk("R8", 0, 0, 7'h52, 1, 0);
    rchk("R8 status", 5'd8, 8'h20);
    rchk("R8 ext", 5'd9, 8'h00);

    // R11 / R13 reads
    rx_byte = 8'h9A;
    acc(1'b0, 5'd0, 8'h00, x);
    check("R13 byte returned in access", x, 8'h9A);
    check("R11 restart count", ncmd, 3);
    logchk("R11", 0, 2, 0, 0, 0);
    logchk("R11", 1, 3, 0, 0, 0);
    logchk("R11", 2, 0, 7'h52, 1, 0);
    rchk("R11 count 1", 5'd6, 8'h13);
    rx_byte = 8'h5B;
    acc(1'b0, 5'd0, 8'h00, x);
    check("R11 data", x, 8'h5B);
    rchk("R11 count 0", 5'd6, 8'h03);
    rx_byte = 8'h77;
    acc(1'b0, 5'd0, 8'h00, x);
    check("R11 last data", x, 8'h77);
    check("R11 last command count", ncmd, 1);
    rchk("R11 wrap", 5'd6, 8'h33);
    rchk("R11 full cleared", 5'd8, 8'h00);
    acc(1'b0, 5'd0, 8'h00, x);
    check("R10 after drain", x, 8'hFF);
    check("R10 after drain cmds", ncmd, 0);

    // R8 with active transfer, then refused receive
    wr(5'd6, 8'h03);
    check("R8 stop then start", ncmd, 2);
    logchk("R8", 0, 3, 0, 0, 0);
    logchk("R8", 1, 0, 7'h52, 1, 0);
    nack_recv = 1;
    acc(1'b0, 5'd0, 8'h00, x);
    nack_recv = 0;
    check("R11 refused receive", x, 8'hFF);
    rchk("R11 wrap after refusal", 5'd6, 8'h33);

    // R8 read start refused
    nack_start = 1;
    wr(5'd6, 8'h03);
    nack_start = 0;
    check("R8 fail count", ncmd, 2);
    rchk("R8 fail status", 5'd8, 8'h04);
    rchk("R8 fail ext", 5'd9, 8'h01);

    // R12
    wr(5'd15, 8'h02);
    rchk("R12 stored", 5'd15, 8'h02);
    wr(5'd7, 8'h10);
    wr(5'd15, 8'h03);
    rchk("R12 xctl", 5'd15, 8'h00);
    rchk("R12 mode", 5'd7, 8'h00);
    rchk("R12 ext", 5'd9, 8'h8F);
    rchk("R12 dir", 5'd16, 8'h0F);
    rchk("R12 ctl", 5'd6, 8'h00);
    rchk("R12 status", 5'd8, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule